// File: doc/BRIEF.md
# Instruction Address Breakpoint Bank

This block holds a small set of hardware breakpoint slots for a processor's debug logic. Each slot has a 32-bit control word and a 64-bit address word. Both are loaded through a single-cycle register write port and read back through a combinational read port. Both words are normalized as they are stored. Control bits that have no meaning are dropped, and the byte-lane field is pinned to all ones. The address word is sign-extended above the top virtual-address bit, and its two low bits are cleared.

In every cycle, a retiring program counter may be presented together with its privilege level. The bank compares it against all slots in parallel. A slot matches only if it is enabled, its type field selects a plain unlinked address match, the privilege level is allowed by its mode field, and the word address agrees. One clock later the bank raises a registered hit flag and gives the index of the lowest-numbered matching slot.

Top module: `bkpt_bank`

## Requirements
- R1: After a synchronous active-low reset, every slot reads control 0x000001E0 and address 0, and `hit` and `hit_slot` are 0.
- R2: A control write keeps only bit 0 (enable), bits 2:1 (mode), bit 13, bits 15:14, bits 19:16 and bits 23:20 (type). All other bits read back 0, except bits 8:5, which always read 1111.
- R3: An address write stores bits 52:2 as given. Bits 63:53 read back as copies of bit 52, and bits 1:0 read back 0.
- R4: A slot can match only when control bit 0 is 1 and control bits 23:20 are 0.
- R5: The address compare uses PC bits 52:2 against stored bits 52:2. PC bits 63:53 and 1:0 have no effect.
- R6: With `pc_priv`=1, a slot needs control bit 1 set to match. With `pc_priv`=0, it needs control bit 2 set.
- R7: When several slots match, `hit_slot` reports the lowest-numbered one.
- R8: `hit` and `hit_slot` are registered and refer to the PC presented in the previous cycle. With no `pc_valid` in that cycle, both are 0, and `hit_slot` is 0 whenever `hit` is 0.
- R9: A PC presented in the same cycle as a write is compared against the slot contents from before the write. The new contents apply to PCs presented from the next cycle on.
- R10: `wr_sel`=0 writes the control word and `wr_sel`=1 writes the address word of slot `wr_slot`. No other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = address word |
| wr_slot | input | IDX_W | Slot written |
| wr_data | input | XLEN | Write data |
| rd_slot | input | IDX_W | Slot read |
| rd_ctrl | output | 32 | Normalized control word of `rd_slot` |
| rd_value | output | XLEN | Normalized address word of `rd_slot` |
| pc_valid | input | 1 | A PC is presented this cycle |
| pc | input | XLEN | Retiring program counter |
| pc_priv | input | 1 | 1 = privileged level, 0 = unprivileged |
| hit | output | 1 | A slot matched the previous cycle's PC |
| hit_slot | output | IDX_W | Lowest matching slot, 0 when no hit |

## Verification
The register write path and the compare path can both act in the same cycle on the same slot. The bench provokes this by presenting a PC equal to a slot's current address while rewriting that address, and then while disabling the slot. It judges the result against R9: the registered result must reflect the old contents, and the following probes must reflect the new contents. The main sweep reprograms the mode field of all four slots through every combination. It probes matching, non-matching and overlapping addresses at both privilege levels. Expected hits and the lowest index are computed arithmetically from the bench's own copy of the written values.

// File: rtl/bkpt_pkg.sv
// Package: shared field positions, masks and types for the breakpoint bank.
// Assumes a 32-bit control word; address width is set by the modules.
package bkpt_pkg;

    localparam int CTRL_W = 32;

    // Control bits that survive a write (enable, mode, higher, security,
    // link number, type); every other bit is discarded.
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 32'h00FF_E1E7;
    // Byte-lane select is pinned to all ones.
    localparam logic [CTRL_W-1:0] CTRL_FORCE = 32'h0000_01E0;
    localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_FORCE;

    localparam int EN_BIT   = 0;
    localparam int PRIV_BIT = 1;
    localparam int USER_BIT = 2;
    localparam int TYPE_LSB = 20;
    localparam int TYPE_W   = 4;

    // Type code for a plain address match with no linking.
    localparam logic [TYPE_W-1:0] TYPE_ADDR = 4'h0;

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_VALUE = 1'b1
    } reg_sel_e;

    // Normalize a written control word.
    function automatic logic [CTRL_W-1:0] norm_ctrl(input logic [CTRL_W-1:0] d);
        return (d & CTRL_KEEP) | CTRL_FORCE;
    endfunction

endpackage

// File: rtl/bkpt_slot.sv
// Module: one breakpoint slot.
// Stores a normalized control and address word and produces a combinational
// match against the presented PC. Assumes XLEN > VA_MSB >= 3.
module bkpt_slot
    import bkpt_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int VA_MSB = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_value,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [XLEN-1:0]   pc,
    input  logic              pc_priv,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [XLEN-1:0]   value_q,
    output logic              match
);

    localparam int SEXT_SH = XLEN - 1 - VA_MSB;
    localparam logic [XLEN-1:0] LOW_CLR = ~XLEN'(3);
    // Compare mask: address bits VA_MSB down to 2.
    localparam logic [XLEN-1:0] CMP_MASK = ((XLEN'(1) << (VA_MSB + 1)) - XLEN'(1)) & LOW_CLR;

    logic [XLEN-1:0] value_n;
    logic            type_ok;
    logic            priv_ok;
    logic            addr_ok;

    // Sign-extend from VA_MSB and clear the two low bits of written data.
    always_comb begin
        value_n = XLEN'($signed(wr_data << SEXT_SH) >>> SEXT_SH) & LOW_CLR;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl_q <= norm_ctrl(wr_data[CTRL_W-1:0]);
        end
    end

    // Address word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_value) begin
            value_q <= value_n;
        end
    end

    // Gating terms and the address compare for this slot.
    always_comb begin
        type_ok = (ctrl_q[TYPE_LSB +: TYPE_W] == TYPE_ADDR);
        priv_ok = pc_priv ? ctrl_q[PRIV_BIT] : ctrl_q[USER_BIT];
        addr_ok = (((pc ^ value_q) & CMP_MASK) == '0);
        match   = ctrl_q[EN_BIT] && type_ok && priv_ok && addr_ok;
    end

    // R10: a slot that is not written keeps its contents.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl || wr_value) |=> ($stable(ctrl_q) && $stable(value_q)));

    // R3: stored upper bits are copies of VA_MSB and the low bits are clear.
    p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((value_q[XLEN-1:VA_MSB] == '0) || (value_q[XLEN-1:VA_MSB] == '1))
        && (value_q[1:0] == 2'b00));

    // R2: bits 8:5 of the control word always read as ones.
    p_bas_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[8:5] == 4'hF);

endmodule

// File: rtl/bkpt_prio.sv
// Module: lowest-index priority picker.
// Turns a request vector into a one-hot grant, an any flag and a binary
// index. The index is 0 when no request is set.
module bkpt_prio #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so that the lowest set request wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

    // R7: at most one grant, and only on a requesting slot.
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R7: any request yields a grant.
    p_grant_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (grant != '0));

endmodule

// File: rtl/bkpt_bank.sv
// Module: breakpoint comparator bank (top).
// Holds NUM_SLOTS slots written and read through a simple register port and
// compares each presented PC against all of them. The result is registered
// one cycle later as a hit flag and the lowest matching index.
// Assumes NUM_SLOTS >= 1 and that writes complete in one cycle.
module bkpt_bank
    import bkpt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int XLEN      = 64,
    parameter int VA_MSB    = 52,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [IDX_W-1:0]  rd_slot,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic [XLEN-1:0]   rd_value,
    input  logic              pc_valid,
    input  logic [XLEN-1:0]   pc,
    input  logic              pc_priv,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_slot
);

    logic [CTRL_W-1:0]    ctrl_arr  [NUM_SLOTS];
    logic [XLEN-1:0]      value_arr [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] match_vec;
    logic [NUM_SLOTS-1:0] en_vec;
    logic [NUM_SLOTS-1:0] grant;
    logic                 any_match;
    logic [IDX_W-1:0]     low_idx;
    reg_sel_e             sel;

    assign sel = reg_sel_e'(wr_sel);

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic wr_hit;

            // Decode the write strobe for this slot.
            always_comb begin
                wr_hit = wr_en && (wr_slot == IDX_W'(g));
            end

            bkpt_slot #(
                .XLEN   (XLEN),
                .VA_MSB (VA_MSB)
            ) i_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_ctrl  (wr_hit && (sel == SEL_CTRL)),
                .wr_value (wr_hit && (sel == SEL_VALUE)),
                .wr_data  (wr_data),
                .pc       (pc),
                .pc_priv  (pc_priv),
                .ctrl_q   (ctrl_arr[g]),
                .value_q  (value_arr[g]),
                .match    (match_vec[g])
            );

            assign en_vec[g] = ctrl_arr[g][EN_BIT];
        end
    endgenerate

    bkpt_prio #(
        .N     (NUM_SLOTS),
        .IDX_W (IDX_W)
    ) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (match_vec),
        .grant (grant),
        .any   (any_match),
        .idx   (low_idx)
    );

    // Read mux: out-of-range slot numbers read as zero.
    always_comb begin
        rd_ctrl  = '0;
        rd_value = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_slot == IDX_W'(i)) begin
                rd_ctrl  = ctrl_arr[i];
                rd_value = value_arr[i];
            end
        end
    end

    // Register the compare result for the presented PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit      <= 1'b0;
            hit_slot <= '0;
        end else if (pc_valid && any_match) begin
            hit      <= 1'b1;
            hit_slot <= low_idx;
        end else begin
            hit      <= 1'b0;
            hit_slot <= '0;
        end
    end

    // R8: a hit always refers to a PC presented in the previous cycle.
    p_hit_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(pc_valid));

    // R8: no hit means index zero.
    p_idle_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_slot == '0));

    // R4: the reported slot was enabled when the PC was compared.
    p_hit_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((($past(en_vec) >> hit_slot) & NUM_SLOTS'(1)) != '0));

    // R7: the reported slot carried the single grant in the compare cycle.
    p_hit_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(grant) == (NUM_SLOTS'(1) << hit_slot)));

endmodule

// File: tb/test_bkpt_bank.sv
`timescale 1ns/1ps
module test_bkpt_bank;

    localparam int N  = 4;
    localparam int XL = 64;
    localparam int VA = 52;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [IW-1:0] wr_slot = '0;
    logic [XL-1:0] wr_data = '0;
    logic [IW-1:0] rd_slot = '0;
    logic [31:0]   rd_ctrl;
    logic [XL-1:0] rd_value;
    logic          pc_valid = 1'b0;
    logic [XL-1:0] pc = '0;
    logic          pc_priv = 1'b0;
    logic          hit;
    logic [IW-1:0] hit_slot;

    always #2 clk = ~clk;

    bkpt_bank #(.NUM_SLOTS(N), .XLEN(XL), .VA_MSB(VA)) i_bkpt_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_slot(wr_slot), .wr_data(wr_data), .rd_slot(rd_slot),
        .rd_ctrl(rd_ctrl), .rd_value(rd_value), .pc_valid(pc_valid),
        .pc(pc), .pc_priv(pc_priv), .hit(hit), .hit_slot(hit_slot)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_ctrl [N];
    logic [63:0] m_val  [N];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl(input logic [31:0] d);
        logic [31:0] r = 32'h0;
        r[0] = d[0];
        r[2:1] = d[2:1];
        r[8:5] = 4'hF;
        r[13] = d[13];
        r[15:14] = d[15:14];
        r[19:16] = d[19:16];
        r[23:20] = d[23:20];
        return r;
    endfunction

    function automatic logic [63:0] exp_val(input logic [63:0] d);
        logic [63:0] r = d;
        r[1:0] = 2'b00;
        for (int b = 53; b < 64; b++) r[b] = d[52];
        return r;
    endfunction

    function automatic bit slot_hits(input int i, input logic [63:0] a, input bit priv);
        logic [31:0] c = m_ctrl[i];
        bit pok = priv ? c[1] : c[2];
        return c[0] && (c[23:20] == 4'h0) && pok && (a[52:2] == m_val[i][52:2]);
    endfunction

    task automatic wr(input int slot, input bit sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_slot = IW'(slot); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_val[slot] = exp_val(d);
        else m_ctrl[slot] = exp_ctrl(d[31:0]);
    endtask

    task automatic check_reads(input string req);
        for (int i = 0; i < N; i++) begin
            rd_slot = IW'(i);
            #0.1;
            chk({req, " ctrl"}, 64'(rd_ctrl), 64'(m_ctrl[i]));
            chk({req, " value"}, rd_value, m_val[i]);
        end
    endtask

    // Present one PC and check the registered result one cycle later.
    task automatic probe(input string req, input logic [63:0] a, input bit priv, input bit valid);
        bit e_hit = 1'b0;
        int e_idx = 0;
        if (valid) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (slot_hits(i, a, priv)) begin e_hit = 1'b1; e_idx = i; end
            end
        end
        @(negedge clk);
        pc_valid = valid; pc = a; pc_priv = priv;
        @(negedge clk);
        pc_valid = 1'b0;
        chk({req, " hit"}, 64'(hit), 64'(e_hit));
        chk({req, " hit_slot (R7)"}, 64'(hit_slot), 64'(e_idx));
    endtask

    initial begin
        #(4.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [63:0] A = 64'h0000_0000_8000_1000;
    localparam logic [63:0] B = 64'h0000_0000_8000_2004;
    localparam logic [63:0] C = 64'hFFF0_0000_0000_0040;
    localparam logic [63:0] D = 64'h0000_0000_8000_3008;

    initial begin
        for (int i = 0; i < N; i++) begin m_ctrl[i] = 32'h1E0; m_val[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 hit", 64'(hit), 64'd0);
        chk("R1 hit_slot", 64'(hit_slot), 64'd0);
        check_reads("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: control normalization
        wr(1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check_reads("R2 ones");
        wr(1, 1'b0, 64'h0);
        check_reads("R2 zero");
        wr(2, 1'b0, 64'h1234_5678_A5A5_5A5A);
        check_reads("R2 pattern R10");

        // R3: address normalization
        wr(0, 1'b1, 64'h0010_0000_0000_0003);
        chk("R3 sext one", m_val[0], 64'hFFF0_0000_0000_0000);
        check_reads("R3 neg");
        wr(3, 1'b1, 64'hFFE0_1234_5678_9ABF);
        check_reads("R3 pos R10");

        // R4: enable and type gating
        wr(0, 1'b1, A);
        for (int t = 0; t < 16; t++) begin
            wr(0, 1'b0, 64'(32'h7 | (t << 20)));
            probe("R4 type", A, 1'b1, 1'b1);
        end
        wr(0, 1'b0, 64'h6);
        probe("R4 disabled", A, 1'b0, 1'b1);
        wr(0, 1'b0, 64'h7);

        // R5: ignored PC bits
        probe("R5 exact", A, 1'b0, 1'b1);
        probe("R5 high bits", A ^ 64'hFFE0_0000_0000_0000, 1'b1, 1'b1);
        probe("R5 low bits", A | 64'h3, 1'b0, 1'b1);
        probe("R5 bit2", A ^ 64'h4, 1'b0, 1'b1);
        probe("R5 bit52", A ^ 64'h0010_0000_0000_0000, 1'b0, 1'b1);

        // R8: no valid PC means no hit
        probe("R8 no valid", A, 1'b0, 1'b0);

        // R6/R7 sweep: every mode combination over four slots
        wr(0, 1'b1, A); wr(1, 1'b1, B); wr(2, 1'b1, A); wr(3, 1'b1, C);
        for (int cfg = 0; cfg < 256; cfg++) begin
            for (int i = 0; i < N; i++) begin
                int code = (cfg >> (2 * i)) & 3;
                logic [63:0] cw = (code == 0) ? 64'h6 : (code == 1) ? 64'h3 :
                                  (code == 2) ? 64'h5 : 64'h7;
                wr(i, 1'b0, cw);
            end
            for (int p = 0; p < 2; p++) begin
                probe("R6 A", A, p[0], 1'b1);
                probe("R6 B", B, p[0], 1'b1);
                probe("R6 C", C, p[0], 1'b1);
                probe("R6 D", D, p[0], 1'b1);
            end
        end

        // R9: write and compare on the same slot in the same cycle
        wr(0, 1'b0, 64'h7); wr(0, 1'b1, A);
        wr(1, 1'b0, 64'h6); wr(2, 1'b0, 64'h6); wr(3, 1'b0, 64'h6);
        @(negedge clk);
        pc_valid = 1'b1; pc = A; pc_priv = 1'b1;
        wr_en = 1'b1; wr_sel = 1'b1; wr_slot = 2'd0; wr_data = D;
        @(negedge clk);
        pc_valid = 1'b0; wr_en = 1'b0;
        m_val[0] = exp_val(D);
        chk("R9 old value hit", 64'(hit), 64'd1);
        probe("R9 old addr now", A, 1'b1, 1'b1);
        probe("R9 new addr now", D, 1'b1, 1'b1);
        @(negedge clk);
        pc_valid = 1'b1; pc = D; pc_priv = 1'b1;
        wr_en = 1'b1; wr_sel = 1'b0; wr_slot = 2'd0; wr_data = 64'h6;
        @(negedge clk);
        pc_valid = 1'b0; wr_en = 1'b0;
        m_ctrl[0] = exp_ctrl(32'h6);
        chk("R9 old enable hit", 64'(hit), 64'd1);
        probe("R9 disabled now", D, 1'b1, 1'b1);
        check_reads("R9 R10 final");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule